// File: doc/BRIEF.md
# Programmable Rising-Edge Accumulator Channel

This block is a single counter channel that watches one of several input pins and, each time that pin goes from low to high, adds a programmable step to a 32-bit running total. A 32-bit control word sets the behaviour. A mode field in that word turns edge counting on, either plain or with a feedback output. Two pin-number fields choose the watched input and the feedback output pin. With a step of 1 the total is a count of rising edges. A larger step turns it into a scaled total, for example a time base in units other than one edge.

Every pin is passed through a two-flop synchronizer before the block looks for an edge. Software reaches the channel through a simple write port and a simple read port. It can rewrite the control word, the step or the total at any time. A write to the total wins over an accumulate in the same cycle, so writing zero starts a fresh count. In feedback mode the block drives the inverse of the synchronized watched input onto the chosen feedback pin and asserts that pin's output enable.

Top module: `edge_accum_chan`

## Requirements
- R1: After reset the control word, the step and the total all read 0, and every bit of `pin_oe` and `pin_out` is 0.
- R2: When control bits 30:26 equal 5'b01010, each 0-to-1 transition of the pin numbered by control bits 4:0 adds the step to the total. The new total is visible after the third rising clock edge following the input change.
- R3: A falling edge, or a pin held at either level, adds nothing to the total.
- R4: With any mode value other than 5'b01010 or 5'b01011, the total does not change except by a write, and `pin_oe` is 0.
- R5: Transitions on pins other than the selected one add nothing.
- R6: The step is the value last written with `wr_sel`=1. The total wraps modulo 2^32.
- R7: A write to the total (`wr_sel`=2) in the same cycle as a detected edge loads the written value, and the step is not added. After a write of 0, counting resumes from 0.
- R8: When control bits 30:26 equal 5'b01011, edges are counted as in R2. `pin_oe` is one-hot at the pin numbered by control bits 13:9, and that bit of `pin_out` is the inverse of the synchronized watched input. All other `pin_out` bits are 0.
- R9: `rd_data` shows the control word for `rd_sel`=0, the step for 1, the total for 2, and 0 for 3. It follows `rd_sel` in the same cycle.
- R10: A write with `wr_en`=1 loads `wr_data` into the register that `wr_sel` names (0 control, 1 step, 2 total) at the next rising clock edge. `wr_sel`=3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | PIN_COUNT | Asynchronous input pins |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 step, 2 total |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 step, 2 total, 3 zero |
| rd_data | output | DATA_W | Read data (combinational) |
| pin_oe | output | PIN_COUNT | Output enable per pin (feedback mode only) |
| pin_out | output | PIN_COUNT | Output value per pin |

## Verification
An input change reaches the total after three rising clock edges: two synchronizer flops, then the edge flop and the accumulate. The feedback output follows the input two edges after it changes. A register write shows on `rd_data` one edge after it is issued. The bench drives every input just after a falling edge and samples every output at the falling edge. A behavioural model steps on every rising edge and is compared at each falling edge. Directed checks then count exactly two and three edges after each pin change to confirm the boundary of the latency. The write-priority case is placed so that the write lands on the very edge at which the accumulate would occur.

// File: rtl/eda_pkg.sv
// Shared constants for the edge accumulator channel.
// Assumes a 32-bit control word with fixed field positions.
package eda_pkg;
    localparam int MODE_LSB = 26;
    localparam int MODE_W   = 5;
    localparam int PSEL_W   = 5;
    localparam int IN_LSB   = 0;
    localparam int FB_LSB   = 9;
    localparam logic [MODE_W-1:0] MODE_RISE    = 5'b01010;
    localparam logic [MODE_W-1:0] MODE_RISE_FB = 5'b01011;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STEP = 2'd1;
    localparam logic [1:0] SEL_ACC  = 2'd2;
endpackage

// File: rtl/eda_sync.sv
// Two-flop synchronizer, one chain per pin.
// Assumes inputs are asynchronous to clk; reset value is low.
module eda_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            logic st1, st2;
            // Two stages of resampling for each pin
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st1 <= 1'b0;
                    st2 <= 1'b0;
                end else begin
                    st1 <= d[g];
                    st2 <= st1;
                end
            end
            assign q[g] = st2;
        end
    endgenerate
endmodule

// File: rtl/eda_edge.sv
// Selects one synchronized pin and flags its rising transitions.
// Assumes pin numbers at or above N read as a constant low.
module eda_edge #(
    parameter int N      = 32,
    parameter int PSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      sync_pins,
    input  logic [PSEL_W-1:0] pin_sel,
    output logic              level,
    output logic              rise
);
    logic prev;

    // Pick the watched pin by number
    always_comb begin
        level = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pin_sel == PSEL_W'(i)) level = sync_pins[i];
        end
    end

    // Remember the previous watched level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign rise = level & ~prev;
endmodule

// File: rtl/eda_regs.sv
// Control, step and total registers with write-over-accumulate priority.
// Assumes the total is updated only on an enabled rising edge or a write.
module eda_regs
    import eda_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] step_q,
    output logic [DATA_W-1:0] acc_q
);
    logic [MODE_W-1:0] mode;
    logic              count_en;

    assign mode     = ctrl_q[MODE_LSB +: MODE_W];
    assign count_en = rise && ((mode == MODE_RISE) || (mode == MODE_RISE_FB));

    // Control word and step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            step_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) ctrl_q <= wr_data;
            if (wr_sel == SEL_STEP) step_q <= wr_data;
        end
    end

    // Running total: write first, else accumulate on an edge
    always_ff @(posedge clk) begin
        if (!rst_n)                          acc_q <= '0;
        else if (wr_en && wr_sel == SEL_ACC) acc_q <= wr_data;
        else if (count_en)                   acc_q <= acc_q + step_q;
    end
endmodule

// File: rtl/edge_accum_chan.sv
// Rising-edge accumulator channel: sync, select, count, feedback, read port.
// Assumes one channel per instance and a plain register read/write port.
module edge_accum_chan
    import eda_pkg::*;
#(
    parameter int PIN_COUNT = 32,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pins_in,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [1:0]           rd_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_out
);
    logic [PIN_COUNT-1:0] sync_pins;
    logic [DATA_W-1:0]    ctrl_q, step_q, acc_q;
    logic                 level, rise, fb_on;
    logic [PSEL_W-1:0]    in_sel, fb_sel;

    assign in_sel = ctrl_q[IN_LSB +: PSEL_W];
    assign fb_sel = ctrl_q[FB_LSB +: PSEL_W];
    assign fb_on  = (ctrl_q[MODE_LSB +: MODE_W] == MODE_RISE_FB);

    eda_sync #(.N(PIN_COUNT)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_in), .q(sync_pins)
    );

    eda_edge #(.N(PIN_COUNT), .PSEL_W(PSEL_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_pins(sync_pins),
        .pin_sel(in_sel), .level(level), .rise(rise)
    );

    eda_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rise(rise),
        .ctrl_q(ctrl_q), .step_q(step_q), .acc_q(acc_q)
    );

    genvar g;
    generate
        for (g = 0; g < PIN_COUNT; g++) begin : g_fb
            // Drive the inverted watched level on the feedback pin only
            assign pin_oe[g]  = fb_on && (fb_sel == PSEL_W'(g));
            assign pin_out[g] = pin_oe[g] & ~level;
        end
    endgenerate

    // Read multiplexer
    always_comb begin
        case (rd_sel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_STEP: rd_data = step_q;
            SEL_ACC:  rd_data = acc_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/eda_chk.sv
// Property checker for edge_accum_chan, attached by bind.
// Assumes it sees the channel's ports and its three internal registers.
module eda_chk #(
    parameter int PIN_COUNT = 32,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_sel,
    input logic [DATA_W-1:0]    wr_data,
    input logic [DATA_W-1:0]    ctrl_q,
    input logic [DATA_W-1:0]    step_q,
    input logic [DATA_W-1:0]    acc_q,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic [PIN_COUNT-1:0] pin_out
);
    logic acc_wr, edge_mode;
    assign acc_wr    = wr_en && (wr_sel == 2'd2);
    assign edge_mode = (ctrl_q[30:26] == 5'b01010) || (ctrl_q[30:26] == 5'b01011);

    AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_oe)); // R8
    AST_OE_ONLY_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe != '0) |-> (ctrl_q[30:26] == 5'b01011)); // R4
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (acc_q == $past(wr_data))); // R7
    AST_HOLD_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && !acc_wr) |=> $stable(acc_q)); // R4
    AST_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> (acc_q == $past(acc_q) || acc_q == $past(acc_q) + $past(step_q))); // R6
endmodule

bind edge_accum_chan eda_chk #(.PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .step_q(step_q), .acc_q(acc_q),
    .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/tb_edge_accum_chan.sv
`timescale 1ns/1ps
module tb_edge_accum_chan;
    localparam int N = 32;
    localparam logic [31:0] M_RISE = 32'(5'b01010) << 26;
    localparam logic [31:0] M_FB   = 32'(5'b01011) << 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pins_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd2;
    logic [31:0] rd_data;
    logic [N-1:0] pin_oe, pin_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    edge_accum_chan dut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // Behavioural reference: history of pin samples and register values
    logic [N-1:0] hist[$];
    bit           m_prev;
    logic [31:0]  m_ctrl, m_step, m_acc;

    function automatic bit watched(logic [N-1:0] v, logic [31:0] c);
        return v[c[4:0]];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {'0, '0};
            m_prev = 1'b0;
            m_ctrl = '0; m_step = '0; m_acc = '0;
        end else begin
            bit now_lvl, hit;
            int md;
            now_lvl = watched(hist[0], m_ctrl);
            md = int'(m_ctrl[30:26]);
            hit = now_lvl && !m_prev && (md == 10 || md == 11);
            if (wr_en && wr_sel == 2'd2) m_acc = wr_data;
            else if (hit) m_acc = m_acc + m_step;
            m_prev = now_lvl;
            if (wr_en && wr_sel == 2'd0) m_ctrl = wr_data;
            if (wr_en && wr_sel == 2'd1) m_step = wr_data;
            void'(hist.pop_front());
            hist.push_back(pins_in);
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference at the falling edge
    always @(negedge clk) begin
        if (rst_n && hist.size() == 2) begin
            logic [N-1:0] e_oe, e_out;
            e_oe = '0; e_out = '0;
            if (m_ctrl[30:26] == 5'b01011) begin
                e_oe[m_ctrl[13:9]] = 1'b1;
                e_out[m_ctrl[13:9]] = ~watched(hist[0], m_ctrl);
            end
            if (rd_sel == 2'd2) chk("R2 model total", rd_data, m_acc);
            chk("R8 model oe", pin_oe, e_oe);
            chk("R8 model out", pin_out, e_out);
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(int p);
        pins_in[p] = 1'b1; tick(4);
        pins_in[p] = 1'b0; tick(4);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        rd_sel = 2'd0; #0.1 chk("R1 ctrl reset", rd_data, 0);
        rd_sel = 2'd1; #0.1 chk("R1 step reset", rd_data, 0);
        rd_sel = 2'd2; #0.1 chk("R1 total reset", rd_data, 0);
        chk("R1 oe reset", pin_oe, 0);
        chk("R1 out reset", pin_out, 0);
        rd_sel = 2'd3; #0.1 chk("R9 unused read", rd_data, 0);

        wr(2'd1, 32'd1);
        wr(2'd0, M_RISE | 32'd3);
        rd_sel = 2'd0; #0.1 chk("R10 ctrl write", rd_data, M_RISE | 32'd3);
        rd_sel = 2'd1; #0.1 chk("R9 step read", rd_data, 1);
        wr(2'd3, 32'hDEAD_BEEF);
        rd_sel = 2'd0; #0.1 chk("R10 sel3 no write", rd_data, M_RISE | 32'd3);
        rd_sel = 2'd2;
        chk("R4 plain mode no oe", pin_oe, 0);

        // Latency: total moves on the third edge, not the second
        pins_in[3] = 1'b1;
        tick(2); chk("R2 not before third edge", rd_data, 0);
        tick(1); chk("R2 first edge counted", rd_data, 1);
        tick(5); chk("R3 high level adds nothing", rd_data, 1);
        pins_in[3] = 1'b0;
        tick(5); chk("R3 falling edge adds nothing", rd_data, 1);

        for (int k = 0; k < 4; k++) pulse(4);
        chk("R5 other pin ignored", rd_data, 1);
        for (int k = 0; k < 3; k++) pulse(3);
        chk("R2 three more edges", rd_data, 4);

        wr(2'd1, 32'd5);
        pulse(3);
        chk("R6 step of five", rd_data, 9);
        wr(2'd2, 32'hFFFF_FFFE);
        pulse(3);
        chk("R6 wrap", rd_data, 32'd3);

        // Write lands on the same edge as the accumulate
        pins_in[3] = 1'b1;
        tick(2);
        wr(2'd2, 32'd100);
        chk("R7 write beats accumulate", rd_data, 100);
        tick(3);
        pins_in[3] = 1'b0; tick(4);
        pulse(3);
        chk("R7 count after write", rd_data, 105);
        wr(2'd2, 32'd0);
        chk("R7 clear", rd_data, 0);
        pulse(3);
        chk("R7 resume from zero", rd_data, 5);

        wr(2'd0, 32'd3);
        pulse(3);
        chk("R4 mode zero ignores edges", rd_data, 5);
        chk("R4 mode zero no oe", pin_oe, 0);
        wr(2'd0, (32'(5'b01001) << 26) | 32'd3);
        pulse(3);
        chk("R4 mode 01001 ignores edges", rd_data, 5);

        wr(2'd0, M_FB | (32'd7 << 9) | 32'd3);
        chk("R8 oe on pin 7", pin_oe, 32'h80);
        chk("R8 out high while input low", pin_out, 32'h80);
        pins_in[3] = 1'b1;
        tick(1); chk("R8 out holds before sync", pin_out, 32'h80);
        tick(1); chk("R8 out inverts input", pin_out, 0);
        tick(1); chk("R8 feedback mode counts", rd_data, 10);
        pins_in[3] = 1'b0;
        tick(3); chk("R8 out back high", pin_out, 32'h80);

        tick(4);
        finish_run();
    end
endmodule